// File: doc/BRIEF.md
# Strobe-Driven FIFO with Retransmit

This block is a first-in first-out word buffer, nine bits wide and `DEPTH` words deep (2048 or 4096 in normal use; any power of two works). A producer writes by pulling `wr_n` low and releasing it. The word on `data_in` is taken when the strobe goes back high. A consumer reads by pulling `rd_n` low. The oldest word then appears on `data_out` with `out_valid` high, and it is retired when the strobe returns high. Both strobes are asynchronous to `clk`, so each passes through a synchroniser before any edge is detected. Flags and errors are produced in the `clk` domain.

Two active-low flags report occupancy. `empty_n` is low when nothing is stored, and `full_n` is low when `DEPTH` words are held. A strobe that falls while its flag blocks it is dropped, and `err` pulses for one cycle. A low pulse on `rt_n` rewinds the read side to location zero so that the stored data can be replayed. The write pointer is left alone, and occupancy is reloaded with the write pointer's value. This rewind is honoured only in single-device mode (`chain_in` low) and only while both strobes are high and no transfer is in progress.

Control is held in two small state machines. The write machine has the states WS_IDLE and WS_HOLD. WS_IDLE moves to WS_HOLD on a falling write strobe when the buffer is not full, and WS_HOLD returns to WS_IDLE on the rising strobe, which commits the word. The read machine has the states RS_IDLE and RS_SHOW. RS_IDLE moves to RS_SHOW on a falling read strobe when the buffer is not empty, and RS_SHOW returns to RS_IDLE on the rising strobe, which retires the word. All other combinations hold the current state.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low and right after it rises, `empty_n`=0, `full_n`=1, `out_valid`=0, `err`=0 and `data_out`=0.
- R2: A write is armed by the falling edge of `wr_n` only when `full_n` is 1. The stored word is the value on `data_in` when `wr_n` returns high, not the value present at the falling edge.
- R3: Reads return the accepted words in the order in which they were written.
- R4: A falling `rd_n` while `empty_n` is 0 is dropped: `out_valid` stays 0 and the occupancy is unchanged.
- R5: `full_n` goes to 0 once `DEPTH` words are stored. A further write is dropped, and `full_n` returns to 1 after one read completes.
- R6: `empty_n` is 1 after any completed write and goes to 0 when the last stored word has been read.
- R7: A low pulse on `rt_n` while `chain_in` is 0 and both strobes are high sets the read pointer to location 0 and keeps the write pointer. The occupancy becomes the write pointer's value, so the next reads replay the words from location 0 on.
- R8: With `chain_in` at 1, a pulse on `rt_n` has no effect on flags or data.
- R9: A pulse on `rt_n` while either strobe is low has no effect.
- R10: `out_valid` is 1 from read acceptance until `rd_n` returns high, and `data_out` holds the word steady during that time. At all other times `data_out` is 0.
- R11: Each dropped write or read raises `err` for exactly one `clk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears pointers and occupancy |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| rt_n | input | 1 | Active-low retransmit pulse, asynchronous |
| chain_in | input | 1 | Low selects single-device mode, in which retransmit is allowed |
| data_in | input | 9 | Word to store, taken at the rising write strobe |
| data_out | output | 9 | Word being read; zero when not valid |
| out_valid | output | 1 | High while a read is presenting a word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| err | output | 1 | One-cycle pulse on a dropped write or read |

## Verification
The bench runs a 16-word instance. It fills the buffer word by word and checks both flags after every write, so a full compare that is off by one shows up as `full_n` falling one word early or late. Writes while full and reads while empty are counted against `err`. A pulse that is lost or lasts longer than one cycle changes the count, and a dropped word that gets stored anyway appears in the drained sequence. Retransmit is swept over every fill level below the depth, each with a partial drain first. A rewind that moved the write pointer, or that did not reload the occupancy, would replay the wrong words or report the wrong flags. Retransmit is also tried in chained mode and while a write strobe is held low, and in both cases any rewind that took place would bring back old words.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned WORD_W = 9;

    typedef enum logic {
        WS_IDLE,
        WS_HOLD
    } wr_state_e;

    typedef enum logic {
        RS_IDLE,
        RS_SHOW
    } rd_state_e;

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level,
    output logic last_level
);

    // Synchroniser stages plus one history stage; idle level is high.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], strobe_n};
        end
    end

    assign level      = chain_q[STAGES-1];
    assign last_level = chain_q[STAGES];

endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 9,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/sfifo_track.sv
module sfifo_track #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          rewind,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (rewind) begin
            // Read side restarts at location zero; occupancy follows wptr.
            rptr  <= '0;
            count <= {1'b0, wptr};
        end else begin
            if (push) begin
                wptr <= wptr + 1'b1;
            end
            if (pop) begin
                rptr <= rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic              chain_in,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] data_out,
    output logic              out_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic              err
);

    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int NSTB = 3;
    localparam int IW   = 0;
    localparam int IR   = 1;
    localparam int IT   = 2;

    // ---------------- strobe synchronisation ----------------
    logic [NSTB-1:0] raw_n;
    logic [NSTB-1:0] lvl;
    logic [NSTB-1:0] prv;

    assign raw_n = {rt_n, rd_n, wr_n};

    generate
        for (genvar g = 0; g < NSTB; g++) begin : g_sync
            sfifo_strobe_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk        (clk),
                .rst_n      (rst_n),
                .strobe_n   (raw_n[g]),
                .level      (lvl[g]),
                .last_level (prv[g])
            );
        end
    endgenerate

    logic w_fall, w_rise, r_fall, r_rise, t_fall;

    assign w_fall = prv[IW] & ~lvl[IW];
    assign w_rise = ~prv[IW] & lvl[IW];
    assign r_fall = prv[IR] & ~lvl[IR];
    assign r_rise = ~prv[IR] & lvl[IR];
    assign t_fall = prv[IT] & ~lvl[IT];

    // ---------------- occupancy ----------------
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              is_full, is_empty;
    logic              push, pop, rewind, rd_issue;
    logic              w_drop, r_drop;
    logic [WORD_W-1:0] ram_q;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);

    // ---------------- write state machine ----------------
    wr_state_e wst, wnxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wst <= WS_IDLE;
        end else begin
            wst <= wnxt;
        end
    end

    always_comb begin
        wnxt = wst;
        unique case (wst)
            WS_IDLE: if (w_fall && !is_full) wnxt = WS_HOLD;
            WS_HOLD: if (w_rise)             wnxt = WS_IDLE;
            default: wnxt = WS_IDLE;
        endcase
    end

    assign push   = (wst == WS_HOLD) && w_rise;
    assign w_drop = (wst == WS_IDLE) && w_fall && is_full;

    // ---------------- read state machine ----------------
    rd_state_e rst_q, rnxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q <= RS_IDLE;
        end else begin
            rst_q <= rnxt;
        end
    end

    always_comb begin
        rnxt = rst_q;
        unique case (rst_q)
            RS_IDLE: if (r_fall && !is_empty) rnxt = RS_SHOW;
            RS_SHOW: if (r_rise)              rnxt = RS_IDLE;
            default: rnxt = RS_IDLE;
        endcase
    end

    assign rd_issue = (rst_q == RS_IDLE) && r_fall && !is_empty;
    assign pop      = (rst_q == RS_SHOW) && r_rise;
    assign r_drop   = (rst_q == RS_IDLE) && r_fall && is_empty;

    // Rewind only in single-device mode with both strobes idle high.
    assign rewind = t_fall && !chain_in && lvl[IW] && lvl[IR]
                    && (wst == WS_IDLE) && (rst_q == RS_IDLE);

    // ---------------- datapath ----------------
    sfifo_track #(
        .DEPTH (DEPTH)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .rewind (rewind),
        .wptr   (wptr),
        .rptr   (rptr),
        .count  (count)
    );

    sfifo_ram #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (push),
        .waddr (wptr),
        .wdata (data_in),
        .re    (rd_issue),
        .raddr (rptr),
        .rdata (ram_q)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            err       <= 1'b0;
        end else begin
            out_valid <= (rnxt == RS_SHOW);
            err       <= w_drop | r_drop;
        end
    end

    assign data_out = out_valid ? ram_q : '0;
    assign empty_n  = !is_empty;
    assign full_n   = !is_full;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] data_out,
    input logic       out_valid,
    input logic       empty_n,
    input logic       full_n,
    input logic       err
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n)); // R5

    AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(empty_n)); // R4

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R11

    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(data_out)); // R10

endmodule

bind strobe_fifo strobe_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_out  (data_out),
    .out_valid (out_valid),
    .empty_n   (empty_n),
    .full_n    (full_n),
    .err       (err)
);

// File: tb/tb_strobe_fifo.sv
`timescale 1ns/1ps
module tb_strobe_fifo;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_n, rd_n, rt_n, chain_in;
    logic [8:0] data_in;
    logic [8:0] data_out;
    logic       out_valid, empty_n, full_n, err;

    int checks = 0;
    int errors = 0;
    int err_pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    strobe_fifo #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .chain_in(chain_in), .data_in(data_in), .data_out(data_out),
        .out_valid(out_valid), .empty_n(empty_n), .full_n(full_n), .err(err)
    );

    always @(posedge clk) if (rst_n && err) err_pulses++;

    function automatic logic [8:0] pat(int i);
        return 9'((i * 37 + 5) & 511);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(2);
    endtask

    task automatic push_word(logic [8:0] v);
        data_in = v;
        wr_n = 1'b0;
        settle(5);
        wr_n = 1'b1;
        settle(5);
    endtask

    task automatic pop_word(logic [8:0] exp, string tag);
        rd_n = 1'b0;
        settle(5);
        check(out_valid == 1'b1, {tag, " R10 valid during read"}, out_valid, 1);
        check(data_out == exp, {tag, " read data"}, data_out, exp);
        rd_n = 1'b1;
        settle(5);
        check(out_valid == 1'b0 && data_out == 9'd0, {tag, " R10 idle output"},
              {out_valid, data_out}, 0);
    endtask

    task automatic rt_pulse();
        rt_n = 1'b0;
        settle(4);
        rt_n = 1'b1;
        settle(5);
    endtask

    initial begin
        int e0;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; chain_in = 1'b0;
        data_in = '0; rst_n = 1'b0;
        settle(3);
        check(empty_n == 0 && full_n == 1 && out_valid == 0 && err == 0,
              "R1 flags in reset", {empty_n, full_n, out_valid, err}, 4'b0100);
        rst_n = 1'b1;
        settle(2);
        check(empty_n == 0 && full_n == 1 && out_valid == 0 && err_pulses == 0,
              "R1 after reset", {empty_n, full_n, out_valid}, 3'b010);
        check(data_out == 0, "R1 data_out zero", data_out, 0);

        // R4: read while empty
        e0 = err_pulses;
        rd_n = 1'b0;
        settle(5);
        check(out_valid == 0, "R4 no valid when empty", out_valid, 0);
        rd_n = 1'b1;
        settle(5);
        check(err_pulses == e0 + 1, "R11 err on empty read", err_pulses, e0 + 1);
        check(empty_n == 0, "R4 still empty", empty_n, 0);

        // R5/R6: fill sweep
        for (int i = 0; i < D; i++) begin
            push_word(pat(i));
            check(empty_n == 1, "R6 not empty after write", empty_n, 1);
            check(full_n == ((i == D - 1) ? 0 : 1), "R5 full flag during fill",
                  full_n, (i == D - 1) ? 0 : 1);
        end
        e0 = err_pulses;
        push_word(9'h1AA);
        check(err_pulses == e0 + 1, "R11 err on full write", err_pulses, e0 + 1);
        check(full_n == 0, "R5 stays full after dropped write", full_n, 0);
        pop_word(pat(0), "R3 first word");
        check(full_n == 1, "R5 full released by read", full_n, 1);
        push_word(pat(D));
        check(full_n == 0, "R5 full again", full_n, 0);
        for (int i = 1; i <= D; i++) begin
            pop_word(pat(i), "R3 drain order");
            check(empty_n == ((i == D) ? 0 : 1), "R6 empty flag during drain",
                  empty_n, (i == D) ? 0 : 1);
        end

        // R2: data taken at rising strobe
        data_in = 9'h055;
        wr_n = 1'b0;
        settle(3);
        data_in = 9'h133;
        settle(3);
        wr_n = 1'b1;
        settle(5);
        pop_word(9'h133, "R2 late data");

        // R7: retransmit sweep over fill levels
        for (int n = 1; n < D; n++) begin
            do_reset();
            for (int k = 0; k < n; k++) push_word(pat(n + k));
            for (int k = 0; k < n / 2; k++) pop_word(pat(n + k), "R7 pre-rewind");
            rt_pulse();
            check(empty_n == 1 && full_n == 1, "R7 flags after rewind",
                  {empty_n, full_n}, 2'b11);
            for (int k = 0; k < n; k++) pop_word(pat(n + k), "R7 replay");
            check(empty_n == 0, "R7 empty after replay", empty_n, 0);
        end

        // R8: chained mode ignores retransmit
        do_reset();
        chain_in = 1'b1;
        for (int k = 0; k < 3; k++) push_word(pat(k + 50));
        for (int k = 0; k < 3; k++) pop_word(pat(k + 50), "R8 setup");
        rt_pulse();
        check(empty_n == 0, "R8 rewind ignored in chained mode", empty_n, 0);
        rd_n = 1'b0;
        settle(5);
        check(out_valid == 0, "R8 no replayed data", out_valid, 0);
        rd_n = 1'b1;
        settle(5);
        chain_in = 1'b0;

        // R9: retransmit ignored while a strobe is low
        do_reset();
        push_word(9'h0A1);
        push_word(9'h0B2);
        pop_word(9'h0A1, "R9 setup");
        pop_word(9'h0B2, "R9 setup");
        data_in = 9'h0C3;
        wr_n = 1'b0;
        settle(5);
        rt_pulse();
        wr_n = 1'b1;
        settle(5);
        check(empty_n == 1, "R9 one word stored", empty_n, 1);
        pop_word(9'h0C3, "R9 no rewind");
        check(empty_n == 0, "R9 empty after single word", empty_n, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R1-all watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule